// File: doc/BRIEF.md
# Big-Endian Load/Store Data Aligner

This block sits between a processor core's load/store unit and a 32-bit data bus that uses big-endian byte numbering. Byte offset 0 is the most significant lane. For a load it picks the addressed byte or halfword out of the raw bus word. It then widens that value to a full register, filling the upper bits with zeros or with copies of the sign bit, depending on the access type. For a store it copies the low byte or low halfword of the register across the bus, and it produces one enable strobe per byte lane so that memory writes only the addressed lanes.

A request is offered for one cycle with `in_valid`. One cycle later the block presents the registered result with `out_valid`. A small two-state controller sequences this. It stays in `ST_IDLE` while no request arrives. It moves to `ST_RESULT` on any cycle that has `in_valid` set (transitions IDLE→RESULT and RESULT→RESULT). It returns to `ST_IDLE` on the first cycle without a request (transition RESULT→IDLE). Misaligned accesses and unused access-type codes are flagged instead of producing data.

Top module: `be_data_aligner`

## Requirements
- R1: `acc_type` is encoded as follows: 0 = byte unsigned, 1 = byte signed, 2 = halfword unsigned, 3 = halfword signed, 4 = word. Codes 5 to 7 set `bad_type` and force `load_data`, `bus_wdata` and `byte_en` to zero.
- R2: On a byte load, `addr_lo` selects the lane: 0 selects bus bits 31:24, 1 selects 23:16, 2 selects 15:8 and 3 selects 7:0. The byte lands in result bits 7:0. An unsigned byte load zero-fills bits 31:8.
- R3: A signed byte load fills result bits 31:8 with copies of bit 7 of the selected byte.
- R4: On a halfword load, `addr_lo[1]`=0 selects bus bits 31:16 and `addr_lo[1]`=1 selects bits 15:0. The halfword lands in result bits 15:0. An unsigned halfword load zero-fills bits 31:16.
- R5: A signed halfword load fills result bits 31:16 with copies of bit 15 of the selected halfword.
- R6: A halfword store drives register bits 15:0 onto both bus bits 31:16 and bus bits 15:0. `byte_en` is 4'b1100 when `addr_lo[1]`=0 and 4'b0011 when `addr_lo[1]`=1. Bit 3 of `byte_en` is the lane on bus bits 31:24.
- R7: A byte store drives register bits 7:0 onto all four lanes. `byte_en` is one-hot: offset 0 gives 4'b1000, 1 gives 4'b0100, 2 gives 4'b0010 and 3 gives 4'b0001.
- R8: A word access passes data through unchanged: the bus word on loads and the register value on stores. `byte_en` is 4'b1111.
- R9: A halfword access with `addr_lo[0]`=1, or a word access with `addr_lo`≠0, sets `misaligned` and forces `load_data`, `bus_wdata` and `byte_en` to zero. Byte accesses are never misaligned.
- R10: Results appear with `out_valid` high on the cycle after `in_valid`. `out_valid` is low on the cycle after a cycle without `in_valid`. All result outputs hold their values while no request arrives, whatever the other inputs do.
- R11: Reset (`rst_n` low) clears `out_valid`, `load_data`, `bus_wdata`, `byte_en`, `misaligned` and `bad_type`.
- R12: On a load (`is_store`=0), `bus_wdata` is zero. On a store, `load_data` is zero. `byte_en` reports the addressed lanes in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe, one cycle per access |
| is_store | input | 1 | 1 = store, 0 = load |
| addr_lo | input | 2 | Low address bits (byte offset in the word) |
| acc_type | input | 3 | Access size and signedness code |
| bus_rdata | input | 32 | Raw word read from the bus |
| reg_wdata | input | 32 | Register value to be stored |
| out_valid | output | 1 | Result valid, one cycle after the request |
| load_data | output | 32 | Aligned and extended load result |
| bus_wdata | output | 32 | Lane-replicated store data |
| byte_en | output | 4 | Byte-lane strobes, bit 3 = bits 31:24 |
| misaligned | output | 1 | Misaligned halfword or word access |
| bad_type | output | 1 | Unused access-type code |

## Verification
The timing properties assume that `in_valid` is low while reset is held. They also assume that each request's inputs are stable across the clock edge that samples them. The reset property additionally assumes that no request is offered on the edge where reset is released. The bench drives every input at the falling edge and keeps `in_valid` low until after reset deasserts, so both conditions always hold. Idle cycles between requests deliberately scramble the data, address and type inputs. This shows that only `in_valid` moves the registered outputs.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

    localparam logic [2:0] ACC_BYTE_U = 3'd0;
    localparam logic [2:0] ACC_BYTE_S = 3'd1;
    localparam logic [2:0] ACC_HALF_U = 3'd2;
    localparam logic [2:0] ACC_HALF_S = 3'd3;
    localparam logic [2:0] ACC_WORD   = 3'd4;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } seq_state_e;

    function automatic logic is_half(input logic [2:0] code);
        return (code == ACC_HALF_U) || (code == ACC_HALF_S);
    endfunction

    function automatic logic is_byte(input logic [2:0] code);
        return (code == ACC_BYTE_U) || (code == ACC_BYTE_S);
    endfunction

endpackage

// File: rtl/be_load_extract.sv
module be_load_extract
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]         rdata,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [2:0]                acc,
    output logic [DATA_W-1:0]         value
);
    localparam int LANES = DATA_W / 8;
    localparam int HALVES = LANES / 2;
    localparam int OFF_W = $clog2(LANES);

    logic [7:0]  lane [LANES];
    logic [15:0] half [HALVES];
    logic [7:0]  sel_b;
    logic [15:0] sel_h;

    // big-endian numbering: index 0 is the most significant lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = rdata[DATA_W-1-8*g -: 8];
    end
    for (genvar g = 0; g < HALVES; g++) begin : g_half
        assign half[g] = rdata[DATA_W-1-16*g -: 16];
    end

    assign sel_b = lane[off];
    assign sel_h = half[off[OFF_W-1:1]];

    always_comb begin
        unique case (acc)
            ACC_BYTE_U: value = {{(DATA_W-8){1'b0}}, sel_b};
            ACC_BYTE_S: value = {{(DATA_W-8){sel_b[7]}}, sel_b};
            ACC_HALF_U: value = {{(DATA_W-16){1'b0}}, sel_h};
            ACC_HALF_S: value = {{(DATA_W-16){sel_h[15]}}, sel_h};
            ACC_WORD:   value = rdata;
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/be_store_pack.sv
module be_store_pack
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0]           wdata,
    input  logic [$clog2(DATA_W/8)-1:0] off,
    input  logic [2:0]                  acc,
    output logic [DATA_W-1:0]           bus_w,
    output logic [DATA_W/8-1:0]         lanes_en
);
    localparam int LANES = DATA_W / 8;
    localparam int OFF_W = $clog2(LANES);

    logic [LANES-1:0] hit_b;
    logic [LANES-1:0] hit_h;

    // enable bit g covers bits [8g+7:8g]; that lane is byte offset LANES-1-g
    for (genvar g = 0; g < LANES; g++) begin : g_en
        assign hit_b[g] = (off == OFF_W'(LANES-1-g));
        assign hit_h[g] = (off[OFF_W-1:1] == (OFF_W-1)'((LANES-1-g)/2));
    end

    always_comb begin
        if (is_byte(acc)) begin
            bus_w    = {LANES{wdata[7:0]}};
            lanes_en = hit_b;
        end else if (is_half(acc)) begin
            bus_w    = {(LANES/2){wdata[15:0]}};
            lanes_en = hit_h;
        end else if (acc == ACC_WORD) begin
            bus_w    = wdata;
            lanes_en = '1;
        end else begin
            bus_w    = '0;
            lanes_en = '0;
        end
    end
endmodule

// File: rtl/be_access_check.sv
module be_access_check
    import be_align_pkg::*;
#(
    parameter int OFF_W = 2
) (
    input  logic [OFF_W-1:0] off,
    input  logic [2:0]       acc,
    output logic             mis,
    output logic             bad
);
    assign bad = (acc > ACC_WORD);
    assign mis = (is_half(acc) && off[0]) || ((acc == ACC_WORD) && (off != '0));
endmodule

// File: rtl/be_data_aligner.sv
module be_data_aligner
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              is_store,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [2:0]        acc_type,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              out_valid,
    output logic [DATA_W-1:0] load_data,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LANES-1:0]  byte_en,
    output logic              misaligned,
    output logic              bad_type
);
    seq_state_e state_q, state_d;

    logic [DATA_W-1:0] ext_val;
    logic [DATA_W-1:0] pack_val;
    logic [LANES-1:0]  pack_en;
    logic              chk_mis;
    logic              chk_bad;

    be_load_extract #(.DATA_W(DATA_W)) u_extract (
        .rdata (bus_rdata),
        .off   (addr_lo),
        .acc   (acc_type),
        .value (ext_val)
    );

    be_store_pack #(.DATA_W(DATA_W)) u_pack (
        .wdata    (reg_wdata),
        .off      (addr_lo),
        .acc      (acc_type),
        .bus_w    (pack_val),
        .lanes_en (pack_en)
    );

    be_access_check #(.OFF_W(OFF_W)) u_check (
        .off (addr_lo),
        .acc (acc_type),
        .mis (chk_mis),
        .bad (chk_bad)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (in_valid)  state_d = ST_RESULT;
            ST_RESULT: if (!in_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign out_valid = (state_q == ST_RESULT);

    // result registers, loaded only when a request is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_data  <= '0;
            bus_wdata  <= '0;
            byte_en    <= '0;
            misaligned <= 1'b0;
            bad_type   <= 1'b0;
        end else if (in_valid) begin
            misaligned <= chk_mis;
            bad_type   <= chk_bad;
            if (chk_mis || chk_bad) begin
                load_data <= '0;
                bus_wdata <= '0;
                byte_en   <= '0;
            end else begin
                load_data <= is_store ? '0 : ext_val;
                bus_wdata <= is_store ? pack_val : '0;
                byte_en   <= pack_en;
            end
        end
    end
endmodule

// File: rtl/be_data_aligner_chk.sv
module be_data_aligner_chk
    import be_align_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              is_store,
    input logic [OFF_W-1:0]  addr_lo,
    input logic [2:0]        acc_type,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              out_valid,
    input logic [DATA_W-1:0] load_data,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [LANES-1:0]  byte_en,
    input logic              misaligned,
    input logic              bad_type
);
    p_valid_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(load_data) && $stable(bus_wdata) && $stable(byte_en)));

    p_reset_r11: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && load_data == '0 && byte_en == '0));

    p_badtype_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_type > ACC_WORD) |=> (bad_type && load_data == '0 && byte_en == '0));

    p_ubyte_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store && acc_type == ACC_BYTE_U) |=> (load_data[DATA_W-1:8] == '0));

    p_sbyte_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store && acc_type == ACC_BYTE_S)
        |=> (load_data[DATA_W-1:8] == {(DATA_W-8){load_data[7]}}));

    p_uhalf_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store && acc_type == ACC_HALF_U && !addr_lo[0])
        |=> (load_data[DATA_W-1:16] == '0));

    p_shalf_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store && acc_type == ACC_HALF_S && !addr_lo[0])
        |=> (load_data[DATA_W-1:16] == {(DATA_W-16){load_data[15]}}));

    p_half_store_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_store && is_half(acc_type) && !addr_lo[0])
        |=> (bus_wdata[31:16] == bus_wdata[15:0] && $countones(byte_en) == 2));

    p_byte_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_store && is_byte(acc_type)) |=> ($countones(byte_en) == 1 && !misaligned));

    p_word_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && acc_type == ACC_WORD && addr_lo == '0) |=> (byte_en == '1));

    p_misalign_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ((is_half(acc_type) && addr_lo[0]) || (acc_type == ACC_WORD && addr_lo != '0)))
        |=> (misaligned && byte_en == '0 && bus_wdata == '0));

    p_store_noload_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && is_store) |=> (load_data == '0));

    p_load_nowrite_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !is_store) |=> (bus_wdata == '0));
endmodule

bind be_data_aligner be_data_aligner_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/be_data_aligner_test.sv
`timescale 1ns/1ps
module be_data_aligner_test;

    typedef struct packed {
        logic [31:0] ld;
        logic [31:0] wd;
        logic [3:0]  be;
        logic        mis;
        logic        bad;
        logic        st;
        logic [2:0]  ty;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        is_store = 1'b0;
    logic [1:0]  addr_lo = '0;
    logic [2:0]  acc_type = '0;
    logic [31:0] bus_rdata = '0;
    logic [31:0] reg_wdata = '0;
    logic        out_valid;
    logic [31:0] load_data;
    logic [31:0] bus_wdata;
    logic [3:0]  byte_en;
    logic        misaligned;
    logic        bad_type;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit have_last = 1'b0;
    exp_t last;
    exp_t sb_q[$];

    always #2.5 clk = ~clk;

    be_data_aligner uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .is_store(is_store),
        .addr_lo(addr_lo), .acc_type(acc_type), .bus_rdata(bus_rdata),
        .reg_wdata(reg_wdata), .out_valid(out_valid), .load_data(load_data),
        .bus_wdata(bus_wdata), .byte_en(byte_en), .misaligned(misaligned),
        .bad_type(bad_type)
    );

    function automatic exp_t model(bit st, logic [2:0] ty, logic [1:0] a,
                                   logic [31:0] rd, logic [31:0] wd);
        exp_t e = '0;
        logic [7:0]  b;
        logic [15:0] h;
        logic [31:0] ldv = '0;
        logic [31:0] wdv = '0;
        logic [3:0]  be = '0;
        e.st = st;
        e.ty = ty;
        case (a)
            2'd0: b = rd[31:24];
            2'd1: b = rd[23:16];
            2'd2: b = rd[15:8];
            default: b = rd[7:0];
        endcase
        h = a[1] ? rd[15:0] : rd[31:16];
        if (ty > 3'd4) begin
            e.bad = 1'b1;
            return e;
        end
        if (((ty == 3'd2 || ty == 3'd3) && a[0]) || (ty == 3'd4 && a != 2'd0)) begin
            e.mis = 1'b1;
            return e;
        end
        case (ty)
            3'd0: begin ldv = {24'h0, b};          be = 4'b1000 >> a; wdv = {4{wd[7:0]}}; end
            3'd1: begin ldv = {{24{b[7]}}, b};     be = 4'b1000 >> a; wdv = {4{wd[7:0]}}; end
            3'd2: begin ldv = {16'h0, h};          be = a[1] ? 4'b0011 : 4'b1100; wdv = {2{wd[15:0]}}; end
            3'd3: begin ldv = {{16{h[15]}}, h};    be = a[1] ? 4'b0011 : 4'b1100; wdv = {2{wd[15:0]}}; end
            default: begin ldv = rd;               be = 4'b1111; wdv = wd; end
        endcase
        e.be = be;
        if (st) e.wd = wdv;
        else    e.ld = ldv;
        return e;
    endfunction

    function automatic string tag_of(exp_t e);
        if (e.bad) return "R1";
        if (e.mis) return "R9";
        case (e.ty)
            3'd0: return e.st ? "R7" : "R2";
            3'd1: return e.st ? "R7" : "R3";
            3'd2: return e.st ? "R6" : "R4";
            3'd3: return e.st ? "R6" : "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    task automatic compare(exp_t e);
        string t;
        t = tag_of(e);
        check(e.st ? "R12" : t, "load_data", load_data, e.ld);
        check(e.st ? t : "R12", "bus_wdata", bus_wdata, e.wd);
        check(t, "byte_en", {28'h0, byte_en}, {28'h0, e.be});
        check("R9", "misaligned", {31'h0, misaligned}, {31'h0, e.mis});
        check("R1", "bad_type", {31'h0, bad_type}, {31'h0, e.bad});
    endtask

    task automatic drive(bit st, logic [2:0] ty, logic [1:0] a, logic [31:0] rd, logic [31:0] wd);
        @(negedge clk);
        in_valid  = 1'b1;
        is_store  = st;
        acc_type  = ty;
        addr_lo   = a;
        bus_rdata = rd;
        reg_wdata = wd;
        sb_q.push_back(model(st, ty, a, rd, wd));
    endtask

    task automatic idle(logic [31:0] junk);
        @(negedge clk);
        in_valid  = 1'b0;
        is_store  = junk[0];
        acc_type  = junk[6:4];
        addr_lo   = junk[9:8];
        bus_rdata = junk;
        reg_wdata = ~junk;
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #1;
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R10 out_valid: got 1 expected 0");
                end else begin
                    last = sb_q.pop_front();
                    have_last = 1'b1;
                    compare(last);
                end
            end else begin
                if (sb_q.size() != 0) begin
                    n_tests++;
                    n_fail++;
                    $display("FAIL R10 out_valid: got 0 expected 1");
                    void'(sb_q.pop_front());
                end else if (have_last) begin
                    // R10: outputs hold through idle cycles with scrambled inputs
                    check("R10", "hold load_data", load_data, last.ld);
                    check("R10", "hold bus_wdata", bus_wdata, last.wd);
                    check("R10", "hold byte_en", {28'h0, byte_en}, {28'h0, last.be});
                end
            end
        end
    end

    logic [31:0] rd_pat [3] = '{32'h80FF7F01, 32'h7F8001FE, 32'hA5C33C5A};
    logic [31:0] wd_pat [3] = '{32'h123480F7, 32'hCAFE7E55, 32'h0F0FF0F0};

    initial begin
        repeat (3) @(negedge clk);
        // R11: state while reset is held
        check("R11", "out_valid", {31'h0, out_valid}, 32'h0);
        check("R11", "load_data", load_data, 32'h0);
        check("R11", "bus_wdata", bus_wdata, 32'h0);
        check("R11", "byte_en", {28'h0, byte_en}, 32'h0);
        check("R11", "flags", {30'h0, misaligned, bad_type}, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int t = 0; t < 8; t++) begin
                    for (int a = 0; a < 4; a++) begin
                        drive(s[0], t[2:0], a[1:0], rd_pat[p], wd_pat[p]);
                        if (((t + a + p) % 5) == 0) idle(32'hDEAD0000 ^ (t * 97 + a));
                    end
                end
            end
        end
        idle(32'h55AA33CC);
        repeat (4) idle(32'h13579BDF);
        @(negedge clk);
        check("R10", "queue drained", sb_q.size(), 32'h0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule